// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This unit sits beside a memory controller's ECC checker and records what went wrong. The checker reports single-bit (correctable) and multi-bit (uncorrectable) events together with the failing address, the 64-bit data word and the received check bits. The unit keeps a sticky flag per error class, counts correctable errors against a programmable threshold before flagging them, freezes the details of the first flagged error, and raises one level interrupt. A 32-bit register port lets software read the state, mask error classes, enable interrupts and clear flags.

Software normally enables both interrupt sources and sets the single-bit threshold to one. In the interrupt handler it reads the status word, reads the captured fields, and writes the status value back to acknowledge it. The captured check field is 8 bits wide for a 64-bit memory bus and 16 bits wide for a 32-bit one.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register reads zero (both flags clear, threshold 0, count 0, nothing masked or enabled, capture words zero) and `irq` is low.
- R2: Status word at offset 0x00 holds the single-bit flag in bit 0 and the multi-bit flag in bit 1. Writing 1 to a bit clears it and writing 0 leaves it alone, so writing back a value read earlier clears exactly those flags. If a flag is set and cleared in the same cycle, the set wins.
- R3: An unmasked multi-bit event sets status bit 1 on the next clock edge.
- R4: The single-bit register at offset 0x0C holds the threshold in bits 23:16 and the event count in bits 7:0. Each unmasked single-bit event increments the count. When the incremented count would reach a nonzero threshold, status bit 0 is set and the count goes back to 0. A threshold of 1 flags every event.
- R5: With threshold 0 single-bit events never set the flag. The count then saturates at 255.
- R6: A write to offset 0x0C loads threshold and count from the written word. It takes precedence over a single-bit event in the same cycle, which then neither counts nor sets the flag.
- R7: The mask register at offset 0x04 (bit 0 single-bit, bit 1 multi-bit) makes events of a masked class have no effect: no count, no flag, no capture.
- R8: The enable register is at offset 0x08 (bit 0 single-bit, bit 1 multi-bit). `irq` is high exactly while some enabled status flag is set, so it follows a flag change by zero cycles and an event by one cycle.
- R9: An unmasked event in a cycle where both flags are clear loads the capture words: address bits 31:0 at 0x10, address bits 63:32 at 0x14, data bits 63:32 at 0x18 and data bits 31:0 at 0x1C. While any flag is set, the capture words hold their values.
- R10: The captured check field at 0x20 holds all 16 check bits when `bus_narrow` is 1. When it is 0, it holds only bits 7:0 and the upper bits are zero.
- R11: Reads of unused offsets return zero. Writes to capture words or unused offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_sbe | input | 1 | Single-bit error event, one cycle per event |
| ev_mbe | input | 1 | Multi-bit error event, one cycle per event |
| ev_addr | input | ADDR_W | Failing address |
| ev_data | input | 64 | Data word as received |
| ev_chk | input | 16 | Check bits as received |
| bus_narrow | input | 1 | 1 selects 32-bit memory bus (16 check bits), 0 selects 64-bit (8 check bits) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
A wrong count or threshold shows up at the port as a flag, and so an interrupt, arriving one event too early or too late. A capture word that is not frozen reads back different after a later event, within one cycle of that event. A flag that does not clear correctly is visible in the status read and on `irq` in the cycle after the write. Random interleavings of events, masks and register writes are compared after every cycle against a bench model, so a divergence is reported within one cycle of the event that caused it.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
   localparam int REG_W    = 32;
   localparam int DATA_W   = 64;
   localparam int CHK_W    = 16;
   localparam int NCLASS   = 2;
   localparam int IDX_SBE  = 0;
   localparam int IDX_MBE  = 1;
   localparam int THR_LSB  = 16;

   localparam logic [7:0] OFF_STAT = 8'h00;
   localparam logic [7:0] OFF_MASK = 8'h04;
   localparam logic [7:0] OFF_IEN  = 8'h08;
   localparam logic [7:0] OFF_SBE  = 8'h0C;
   localparam logic [7:0] OFF_ALO  = 8'h10;
   localparam logic [7:0] OFF_AHI  = 8'h14;
   localparam logic [7:0] OFF_DHI  = 8'h18;
   localparam logic [7:0] OFF_DLO  = 8'h1C;
   localparam logic [7:0] OFF_CHK  = 8'h20;
endpackage

// File: rtl/ecc_sbe_cnt.sv
module ecc_sbe_cnt #(
   parameter int SBE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [SBE_W-1:0] cfg_thr,
   input  logic [SBE_W-1:0] cfg_cnt,
   input  logic             ev,
   output logic [SBE_W-1:0] thr,
   output logic [SBE_W-1:0] cnt,
   output logic             hit
);
   localparam logic [SBE_W-1:0] CNT_MAX = '1;
   localparam int EXT_W = SBE_W + 1;

   logic [EXT_W-1:0] cnt_inc;

   assign cnt_inc = {1'b0, cnt} + EXT_W'(1);
   // Threshold reached on this event (a configuration write pre-empts it, R6)
   assign hit = ev && !cfg_we && (thr != '0) && (cnt_inc >= {1'b0, thr});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr <= '0;
         cnt <= '0;
      end else if (cfg_we) begin
         thr <= cfg_thr;
         cnt <= cfg_cnt;
      end else if (ev) begin
         if (hit)
            cnt <= '0;
         else if (cnt != CNT_MAX)
            cnt <= cnt_inc[SBE_W-1:0];
      end
   end
endmodule

// File: rtl/ecc_err_flags.sv
module ecc_err_flags #(
   parameter int NCLS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCLS-1:0] set,
   input  logic [NCLS-1:0] clr,
   output logic [NCLS-1:0] flags
);
   for (genvar k = 0; k < NCLS; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[k] <= 1'b0;
         else if (set[k])
            flags[k] <= 1'b1;
         else if (clr[k])
            flags[k] <= 1'b0;
      end
   end
endmodule

// File: rtl/ecc_err_cap.sv
module ecc_err_cap #(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64,
   parameter int CHK_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              narrow,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic [CHK_W-1:0]  chk,
   output logic [31:0]       cap_alo,
   output logic [31:0]       cap_ahi,
   output logic [31:0]       cap_dhi,
   output logic [31:0]       cap_dlo,
   output logic [31:0]       cap_chk
);
   localparam int HALF_CHK = CHK_W / 2;

   logic [63:0]      addr64;
   logic [CHK_W-1:0] chk_eff;
   logic [CHK_W-1:0] chk_q;

   assign addr64  = 64'(addr);
   assign chk_eff = narrow ? chk : {{(CHK_W-HALF_CHK){1'b0}}, chk[HALF_CHK-1:0]};
   assign cap_chk = 32'(chk_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_alo <= '0;
         cap_dhi <= '0;
         cap_dlo <= '0;
         chk_q   <= '0;
      end else if (load) begin
         cap_alo <= addr64[31:0];
         cap_dhi <= data[63:32];
         cap_dlo <= data[31:0];
         chk_q   <= chk_eff;
      end
   end

   if (ADDR_W > 32) begin : g_ext_addr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cap_ahi <= '0;
         else if (load)
            cap_ahi <= addr64[63:32];
      end
   end else begin : g_no_ext_addr
      assign cap_ahi = '0;
   end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
   import ecc_err_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int SBE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_sbe,
   input  logic              ev_mbe,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [63:0]       ev_data,
   input  logic [15:0]       ev_chk,
   input  logic              bus_narrow,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq
);
   if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
      $error("ecc_err_capture: ADDR_W must lie in 1..64");
   end
   if (SBE_W < 1 || SBE_W > THR_LSB || THR_LSB + SBE_W > REG_W) begin : g_bad_sbe_w
      $error("ecc_err_capture: SBE_W must lie in 1..16");
   end

   logic [NCLASS-1:0] dis_q, ien_q, flags_q, st_set, st_clr;
   logic              we_stat, we_mask, we_ien, we_sbe;
   logic              acc_sbe, acc_mbe, sbe_hit, cap_load;
   logic [SBE_W-1:0]  sbe_thr, sbe_cnt;
   logic [31:0]       cap_alo, cap_ahi, cap_dhi, cap_dlo, cap_chk;

   assign we_stat = reg_wr && (reg_addr == OFF_STAT);
   assign we_mask = reg_wr && (reg_addr == OFF_MASK);
   assign we_ien  = reg_wr && (reg_addr == OFF_IEN);
   assign we_sbe  = reg_wr && (reg_addr == OFF_SBE);

   assign acc_sbe = ev_sbe && !dis_q[IDX_SBE];
   assign acc_mbe = ev_mbe && !dis_q[IDX_MBE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q <= '0;
         ien_q <= '0;
      end else begin
         if (we_mask) dis_q <= reg_wdata[NCLASS-1:0];
         if (we_ien)  ien_q <= reg_wdata[NCLASS-1:0];
      end
   end

   ecc_sbe_cnt #(.SBE_W(SBE_W)) i_sbe_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (we_sbe),
      .cfg_thr (reg_wdata[THR_LSB +: SBE_W]),
      .cfg_cnt (reg_wdata[SBE_W-1:0]),
      .ev      (acc_sbe),
      .thr     (sbe_thr),
      .cnt     (sbe_cnt),
      .hit     (sbe_hit)
   );

   always_comb begin
      st_set          = '0;
      st_set[IDX_SBE] = sbe_hit;
      st_set[IDX_MBE] = acc_mbe;
      st_clr          = we_stat ? reg_wdata[NCLASS-1:0] : '0;
   end

   ecc_err_flags #(.NCLS(NCLASS)) i_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (st_set),
      .clr   (st_clr),
      .flags (flags_q)
   );

   assign cap_load = (acc_sbe || acc_mbe) && (flags_q == '0);

   ecc_err_cap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W)) i_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cap_load),
      .narrow  (bus_narrow),
      .addr    (ev_addr),
      .data    (ev_data),
      .chk     (ev_chk),
      .cap_alo (cap_alo),
      .cap_ahi (cap_ahi),
      .cap_dhi (cap_dhi),
      .cap_dlo (cap_dlo),
      .cap_chk (cap_chk)
   );

   assign irq = |(flags_q & ien_q);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFF_STAT: reg_rdata[NCLASS-1:0] = flags_q;
         OFF_MASK: reg_rdata[NCLASS-1:0] = dis_q;
         OFF_IEN:  reg_rdata[NCLASS-1:0] = ien_q;
         OFF_SBE: begin
            reg_rdata[THR_LSB +: SBE_W] = sbe_thr;
            reg_rdata[SBE_W-1:0]        = sbe_cnt;
         end
         OFF_ALO:  reg_rdata = cap_alo;
         OFF_AHI:  reg_rdata = cap_ahi;
         OFF_DHI:  reg_rdata = cap_dhi;
         OFF_DLO:  reg_rdata = cap_dlo;
         OFF_CHK:  reg_rdata = cap_chk;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk #(
   parameter int SBE_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ev_sbe,
   input logic             ev_mbe,
   input logic [1:0]       dis,
   input logic [1:0]       flags,
   input logic [1:0]       clr,
   input logic             cfg_we,
   input logic [SBE_W-1:0] thr,
   input logic [SBE_W-1:0] cnt,
   input logic [31:0]      cap_lo,
   input logic [31:0]      cap_dlo
);
   // R3
   mbe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_mbe && !dis[1]) |=> flags[1]);

   // R3
   mbe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> $past(ev_mbe && !dis[1]));

   // R2
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[1] && !(ev_mbe && !dis[1])) |=> !flags[1]);

   // R9
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags != 2'b00) |=> ($stable(cap_lo) && $stable(cap_dlo)));

   // R7
   sbe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_sbe && dis[0] && !cfg_we) |=> $stable(cnt));

   // R5
   zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr == '0 && !cfg_we && flags[0] == 1'b0) |=> !flags[0]);
endmodule

bind ecc_err_capture ecc_err_capture_chk #(.SBE_W(SBE_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ev_sbe  (ev_sbe),
   .ev_mbe  (ev_mbe),
   .dis     (dis_q),
   .flags   (flags_q),
   .clr     (st_clr),
   .cfg_we  (we_sbe),
   .thr     (sbe_thr),
   .cnt     (sbe_cnt),
   .cap_lo  (cap_alo),
   .cap_dlo (cap_dlo)
);

// File: tb/test_ecc_err_capture.sv
module test_ecc_err_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_sbe = 1'b0, ev_mbe = 1'b0;
   logic [63:0] ev_addr = '0, ev_data = '0;
   logic [15:0] ev_chk = '0;
   logic        bus_narrow = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int total = 0, bad = 0;
   bit finished = 0;

   // bench model
   logic [1:0]  m_flags = '0, m_dis = '0, m_ien = '0;
   logic [7:0]  m_thr = '0, m_cnt = '0;
   logic [31:0] m_alo = '0, m_ahi = '0, m_dhi = '0, m_dlo = '0, m_chk = '0;

   always #4 clk = ~clk;

   ecc_err_capture i_ecc_err_capture (
      .clk(clk), .rst_n(rst_n), .ev_sbe(ev_sbe), .ev_mbe(ev_mbe),
      .ev_addr(ev_addr), .ev_data(ev_data), .ev_chk(ev_chk),
      .bus_narrow(bus_narrow), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a)
         8'h00: return {30'd0, m_flags};
         8'h04: return {30'd0, m_dis};
         8'h08: return {30'd0, m_ien};
         8'h0C: return {8'd0, m_thr, 8'd0, m_cnt};
         8'h10: return m_alo;
         8'h14: return m_ahi;
         8'h18: return m_dhi;
         8'h1C: return m_dlo;
         8'h20: return m_chk;
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_reg(input string req, input logic [7:0] a);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp_read(a));
   endtask

   task automatic chk_all();
      check("R8 irq", {31'd0, irq}, {31'd0, |(m_flags & m_ien)});
      chk_reg("R2 status", 8'h00);
      chk_reg("R7 mask", 8'h04);
      chk_reg("R8 enable", 8'h08);
      chk_reg("R4 sbe reg", 8'h0C);
      chk_reg("R9 addr lo", 8'h10);
      chk_reg("R9 addr hi", 8'h14);
      chk_reg("R9 data hi", 8'h18);
      chk_reg("R9 data lo", 8'h1C);
      chk_reg("R10 check", 8'h20);
   endtask

   // One clock with the given stimulus; the model advances alongside.
   task automatic step(input bit s, input bit m, input logic [63:0] a, input logic [63:0] d,
                       input logic [15:0] c, input bit wr, input logic [7:0] wa,
                       input logic [31:0] wd);
      logic [1:0] clr, nf;
      logic       set_s, acc_s, acc_m;
      logic [7:0] nthr, ncnt;
      @(negedge clk);
      ev_sbe = s; ev_mbe = m; ev_addr = a; ev_data = d; ev_chk = c;
      reg_wr = wr; reg_addr = wa; reg_wdata = wd;
      acc_s = s && !m_dis[0];
      acc_m = m && !m_dis[1];
      clr   = (wr && wa == 8'h00) ? wd[1:0] : 2'b00;
      set_s = 1'b0; nthr = m_thr; ncnt = m_cnt;
      if (wr && wa == 8'h0C) begin
         nthr = wd[23:16]; ncnt = wd[7:0];
      end else if (acc_s) begin
         if (m_thr != 0 && int'(m_cnt) + 1 >= int'(m_thr)) begin
            set_s = 1'b1; ncnt = 8'd0;
         end else if (m_cnt != 8'hFF) begin
            ncnt = m_cnt + 8'd1;
         end
      end
      nf = (m_flags & ~clr) | {acc_m, set_s};
      @(posedge clk);
      if ((acc_s || acc_m) && m_flags == 2'b00) begin
         m_alo = a[31:0]; m_ahi = a[63:32]; m_dhi = d[63:32]; m_dlo = d[31:0];
         m_chk = bus_narrow ? {16'd0, c} : {24'd0, c[7:0]};
      end
      if (wr && wa == 8'h04) m_dis = wd[1:0];
      if (wr && wa == 8'h08) m_ien = wd[1:0];
      m_flags = nf; m_thr = nthr; m_cnt = ncnt;
      #1;
      ev_sbe = 0; ev_mbe = 0; reg_wr = 0;
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] v);
      step(0, 0, '0, '0, '0, 1, a, v);
   endtask

   function automatic logic [63:0] r64();
      return {$urandom, $urandom};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset values (checked while reset is still asserted)
      check("R1 irq", {31'd0, irq}, 32'd0);
      for (int a = 0; a <= 8'h24; a += 4) chk_reg("R1 reset reg", 8'(a));
      rst_n = 1'b1;

      // R4 threshold 1: every single-bit event flags
      wr_reg(8'h08, 32'h3);
      wr_reg(8'h0C, 32'h0001_0000);
      step(1, 0, 64'h1234_5678_9ABC_DEF0, 64'hAAAA_BBBB_CCCC_DDDD, 16'hBEEF, 0, 0, 0);
      chk_all();                   // R4 flag, R9 capture, R10 8-bit field
      // R9 hold: later multi-bit event changes nothing captured
      step(0, 1, r64(), r64(), 16'h1111, 0, 0, 0);
      chk_all();
      // R2 write back the value read
      reg_addr = 8'h00; #1; rd = reg_rdata;
      wr_reg(8'h00, rd);
      chk_all();

      // R4 threshold 3: third event flags, count returns to 0
      wr_reg(8'h0C, 32'h0003_0000);
      step(1, 0, r64(), r64(), 16'h0, 0, 0, 0); chk_all();
      step(1, 0, r64(), r64(), 16'h0, 0, 0, 0); chk_all();
      step(1, 0, r64(), r64(), 16'h0, 0, 0, 0); chk_all();
      wr_reg(8'h00, 32'hFFFF_FFFF); chk_all();

      // R5 threshold 0: saturating count, never flags
      wr_reg(8'h0C, 32'h0000_00F0);
      for (int i = 0; i < 20; i++) step(1, 0, r64(), r64(), 16'h0, 0, 0, 0);
      chk_all();

      // R6 write wins over a simultaneous event
      step(1, 0, r64(), r64(), 16'h0, 1, 8'h0C, 32'h0001_0005);
      chk_all();

      // R7 masked classes do nothing
      wr_reg(8'h04, 32'h3);
      step(1, 1, r64(), r64(), 16'hFFFF, 0, 0, 0);
      chk_all();
      wr_reg(8'h04, 32'h0);

      // R10 narrow bus keeps 16 check bits
      bus_narrow = 1'b1;
      step(0, 1, r64(), r64(), 16'hC3A5, 0, 0, 0);
      chk_all();
      // R2 set wins over clear in the same cycle
      step(0, 1, r64(), r64(), 16'h0, 1, 8'h00, 32'h2);
      chk_all();
      wr_reg(8'h00, 32'h3);

      // R11 unused offsets and read-only words
      wr_reg(8'h10, 32'hDEAD_BEEF);
      wr_reg(8'h30, 32'hFFFF_FFFF);
      chk_reg("R11 unused", 8'h30);
      chk_reg("R11 unused", 8'h24);
      chk_all();

      // Random interleaving
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] wa;
         logic [31:0] wd;
         int sel;
         sel = $urandom % 6;
         wa = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h04 : (sel == 2) ? 8'h08 :
              (sel == 3) ? 8'h0C : (sel == 4) ? 8'h10 : 8'h24;
         wd = $urandom;
         if (wa == 8'h0C) wd = {8'd0, 8'($urandom % 5), 8'd0, 8'($urandom % 4)};
         if (wa == 8'h04) wd = ($urandom % 4 == 0) ? wd : 32'd0;
         bus_narrow = ($urandom % 2) == 1;
         step(($urandom % 3) == 0, ($urandom % 12) == 0, r64(), r64(), 16'($urandom),
              ($urandom % 5) == 0, wa, wd);
         chk_all();
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule